// File: doc/BRIEF.md
# E1 Spare-Bit Maintenance Link Port

This block carries a maintenance data link in the five spare bits of the E1 timeslot-zero word. That word is sent only in frames without the frame alignment pattern. One clock cycle of the block equals one 2.048 Mb/s bit cell. On each side, the framer supplies the current timeslot number, the bit number within the slot (counting 7 down to 0), and a flag that is high for frames carrying the non-alignment word. A five-bit select mask chooses which spare bits belong to the link. Bit 4 of the mask selects the cell at bit number 4, which is the first spare bit. Bit 0 selects bit number 0, which is the last.

On the transmit side, the block gives the external link controller a one-cell strobe in each selected spare-bit cell. It samples the controller's serial bit on the clock edge that raises that strobe, and puts that bit into the outgoing stream in place of the framer's bit. Spare cells that are not selected carry a default value taken from an input bus. All other cells pass the framer's stream through unchanged. On the receive side, the decoded stream is passed through, and a one-cell strobe is raised alongside it in each selected spare cell.

Each selected bit adds 4 kb/s, because the spare bits recur every second frame. The receive strobe is timed only from the receive-side position inputs. If the receive frame position moves because of a slip, the strobe follows it, so no link bit is lost or doubled. Every output is registered, and each output cell lags its input cell by one clock.

Top module: `saLinkPort`

## Requirements
- R1: When the inputs of a side show timeslot 0, bit number b (4..0), in a frame carrying the non-alignment word, and bit b of that side's active mask is set, that side's strobe is high in the next cycle, for exactly that one cycle per such cell.
- R2: The transmit strobe stays low in every other cell: frames carrying the alignment word, timeslots other than 0, and bit numbers 7, 6 and 5.
- R3: In a cycle where the transmit strobe is high, txDataOut equals the value txLinkData had at the clock edge that raised the strobe.
- R4: In an unselected spare cell (timeslot 0, bit b in 4..0, non-alignment frame, mask bit b clear), txDataOut in the next cycle equals txDefaultSa[b].
- R5: In every cell outside the spare cells, txDataOut in the next cycle equals the txDataIn value of that cell.
- R6: rxDataOut always equals rxDataIn one cycle earlier, and the receive strobe rises in the same cycle as the rxDataOut bit of the selected cell.
- R7: Each side copies dlMask into its active mask only at timeslot 0, bit 7, of a non-alignment frame. A change of dlMask at any other time has no effect on the strobes until that point.
- R8: While the active mask is zero, neither strobe pulses.
- R9: Receive strobes follow the receive position inputs alone. After the receive frame position jumps, they fall on the new receive spare cells, whatever the transmit position is.
- R10: While rstN is low, both strobes and both data outputs are 0 and both active masks are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock, one cycle per 2.048 Mb/s cell |
| rstN | input | 1 | Active-low synchronous reset |
| dlMask | input | 5 | Spare-bit select; bit b enables bit number b of timeslot 0 |
| txSlot | input | 5 | Transmit timeslot number of the current cell |
| txBit | input | 3 | Transmit bit number within the slot, 7 first, 0 last |
| txNfas | input | 1 | High while the transmit frame carries the non-alignment word |
| txDataIn | input | 1 | Framer's outgoing serial bit for the current cell |
| txDefaultSa | input | 5 | Values for spare cells not used by the link, indexed by bit number |
| txLinkData | input | 1 | Serial link bit from the external controller |
| txStrobe | output | 1 | Transmit link strobe, one cell wide per selected bit |
| txDataOut | output | 1 | Outgoing serial stream with link bits inserted |
| rxSlot | input | 5 | Receive timeslot number of the current cell |
| rxBit | input | 3 | Receive bit number within the slot |
| rxNfas | input | 1 | High while the receive frame carries the non-alignment word |
| rxDataIn | input | 1 | Decoded receive serial bit |
| rxStrobe | output | 1 | Receive link strobe, one cell wide per selected bit |
| rxDataOut | output | 1 | Decoded receive stream, delayed one cell |

## Verification
The assertions assume that the position inputs always describe a legal cell: the bit number is within 0..7, and the non-alignment flag stays constant for a whole frame. They also assume that every input is steady and known from the first clock after reset. The bench derives each position from a cell counter that runs over 256 cells per frame, and it toggles the frame flag only at frame boundaries. A receive slip is modelled as a fixed cell offset from the transmit counter. At the wrap, that offset inverts the frame flag, so the receive side still sees alternating frames. Data inputs come from a free-running shift register and change only between clock edges.

// File: rtl/saLinkPkg.sv
package saLinkPkg;
  localparam int SA_COUNT = 5;
  localparam int SLOT_W   = 5;
  localparam int BIT_W    = 3;

  typedef struct packed {
    logic             frameStart;
    logic             saCell;
    logic [BIT_W-1:0] saIdx;
  } cellCtrlT;
endpackage

// File: rtl/saCellCtrl.sv
module saCellCtrl
  import saLinkPkg::*;
#(
  parameter int LINK_SLOT = 0
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bitNum,
  input  logic              nfas,
  output cellCtrlT          ctl
);
  localparam logic [SLOT_W-1:0] LinkSlot  = SLOT_W'(LINK_SLOT);
  localparam logic [BIT_W-1:0]  FirstBit  = '1;
  localparam logic [BIT_W-1:0]  SaLimit   = BIT_W'(SA_COUNT);

  logic inLinkSlot;

  always_comb begin
    inLinkSlot     = (slot == LinkSlot) && nfas;
    ctl.frameStart = inLinkSlot && (bitNum == FirstBit);
    ctl.saCell     = inLinkSlot && (bitNum < SaLimit);
    ctl.saIdx      = bitNum;
  end
endmodule

// File: rtl/saMaskLatch.sv
module saMaskLatch
  import saLinkPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cellCtrlT            ctl,
  input  logic [SA_COUNT-1:0] maskIn,
  output logic                selected
);
  logic [SA_COUNT-1:0] activeMask;
  logic [SA_COUNT-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= '0;
    end else if (ctl.frameStart) begin
      activeMask <= maskIn;
    end
  end

  always_comb begin
    shifted  = activeMask >> ctl.saIdx;
    selected = ctl.saCell && shifted[0];
  end
endmodule

// File: rtl/saLinkDatapath.sv
module saLinkDatapath
  import saLinkPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SA_COUNT-1:0] dlMask,
  input  cellCtrlT            txCtl,
  input  cellCtrlT            rxCtl,
  input  logic                txDataIn,
  input  logic [SA_COUNT-1:0] txDefaultSa,
  input  logic                txLinkData,
  input  logic                rxDataIn,
  output logic                txStrobe,
  output logic                txDataOut,
  output logic                rxStrobe,
  output logic                rxDataOut
);
  logic                txSel;
  logic                rxSel;
  logic [SA_COUNT-1:0] defShift;
  logic                txNext;

  saMaskLatch u_txMask (
    .clk(clk), .rstN(rstN), .ctl(txCtl), .maskIn(dlMask), .selected(txSel)
  );

  saMaskLatch u_rxMask (
    .clk(clk), .rstN(rstN), .ctl(rxCtl), .maskIn(dlMask), .selected(rxSel)
  );

  always_comb begin
    defShift = txDefaultSa >> txCtl.saIdx;
    if (txSel) begin
      txNext = txLinkData;
    end else if (txCtl.saCell) begin
      txNext = defShift[0];
    end else begin
      txNext = txDataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStrobe  <= 1'b0;
      txDataOut <= 1'b0;
      rxStrobe  <= 1'b0;
      rxDataOut <= 1'b0;
    end else begin
      txStrobe  <= txSel;
      txDataOut <= txNext;
      rxStrobe  <= rxSel;
      rxDataOut <= rxDataIn;
    end
  end
endmodule

// File: rtl/saLinkPort.sv
module saLinkPort
  import saLinkPkg::*;
#(
  parameter int LINK_SLOT = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SA_COUNT-1:0] dlMask,
  input  logic [SLOT_W-1:0]   txSlot,
  input  logic [BIT_W-1:0]    txBit,
  input  logic                txNfas,
  input  logic                txDataIn,
  input  logic [SA_COUNT-1:0] txDefaultSa,
  input  logic                txLinkData,
  output logic                txStrobe,
  output logic                txDataOut,
  input  logic [SLOT_W-1:0]   rxSlot,
  input  logic [BIT_W-1:0]    rxBit,
  input  logic                rxNfas,
  input  logic                rxDataIn,
  output logic                rxStrobe,
  output logic                rxDataOut
);
  cellCtrlT txCtl;
  cellCtrlT rxCtl;

  saCellCtrl #(.LINK_SLOT(LINK_SLOT)) u_txCtrl (
    .slot(txSlot), .bitNum(txBit), .nfas(txNfas), .ctl(txCtl)
  );

  saCellCtrl #(.LINK_SLOT(LINK_SLOT)) u_rxCtrl (
    .slot(rxSlot), .bitNum(rxBit), .nfas(rxNfas), .ctl(rxCtl)
  );

  saLinkDatapath u_dp (
    .clk(clk), .rstN(rstN), .dlMask(dlMask),
    .txCtl(txCtl), .rxCtl(rxCtl),
    .txDataIn(txDataIn), .txDefaultSa(txDefaultSa), .txLinkData(txLinkData),
    .rxDataIn(rxDataIn),
    .txStrobe(txStrobe), .txDataOut(txDataOut),
    .rxStrobe(rxStrobe), .rxDataOut(rxDataOut)
  );
endmodule

// File: rtl/saLinkPortChk.sv
module saLinkPortChk
  import saLinkPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [SA_COUNT-1:0] dlMask,
  input logic [SLOT_W-1:0]   txSlot,
  input logic [BIT_W-1:0]    txBit,
  input logic                txNfas,
  input logic                txDataIn,
  input logic [SA_COUNT-1:0] txDefaultSa,
  input logic                txLinkData,
  input logic                txStrobe,
  input logic                txDataOut,
  input logic [SLOT_W-1:0]   rxSlot,
  input logic [BIT_W-1:0]    rxBit,
  input logic                rxNfas,
  input logic                rxDataIn,
  input logic                rxStrobe,
  input logic                rxDataOut
);
  logic warm;
  logic txSaNow;
  logic rxSaNow;

  always_ff @(posedge clk) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  assign txSaNow = (txSlot == '0) && txNfas && (txBit < 3'd5);
  assign rxSaNow = (rxSlot == '0) && rxNfas && (rxBit < 3'd5);

  a_r2_tx_only_sa_cells: assert property (@(posedge clk) disable iff (!rstN || !warm)
    txStrobe |-> $past(txSaNow));

  a_r3_link_bit_inserted: assert property (@(posedge clk) disable iff (!rstN || !warm)
    txStrobe |-> (txDataOut == $past(txLinkData)));

  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rstN || !warm)
    !$past(txSaNow) |-> (txDataOut == $past(txDataIn)));

  a_r6_rx_stream_delay: assert property (@(posedge clk) disable iff (!rstN || !warm)
    rxDataOut == $past(rxDataIn));

  a_r9_rx_strobe_follows_rx: assert property (@(posedge clk) disable iff (!rstN || !warm)
    rxStrobe |-> $past(rxSaNow));

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) && warm == 1'b0 && !rstN |-> !txStrobe && !rxStrobe);
endmodule

bind saLinkPort saLinkPortChk u_chk (.*);

// File: tb/saLinkPort_tb.sv
module saLinkPort_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] dlMask = '0;
  logic [4:0] txSlot = '0;
  logic [2:0] txBit = '0;
  logic       txNfas = 1'b0;
  logic       txDataIn = 1'b0;
  logic [4:0] txDefaultSa = '0;
  logic       txLinkData = 1'b0;
  logic       txStrobe;
  logic       txDataOut;
  logic [4:0] rxSlot = '0;
  logic [2:0] rxBit = '0;
  logic       rxNfas = 1'b0;
  logic       rxDataIn = 1'b0;
  logic       rxStrobe;
  logic       rxDataOut;

  int checks = 0;
  int fails = 0;
  logic [4:0] tMask = '0;
  logic [4:0] rMask = '0;
  logic [15:0] lfsr = 16'hACE1;
  int txPulses = 0;
  int rxPulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  saLinkPort u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepCell(input int tc, input bit tn, input int rc, input bit rn);
    bit txSa, rxSa, eTxS, eTxD, eRxS, eRxD;
    string tag;
    txSlot = 5'(tc / 8); txBit = 3'(7 - tc % 8); txNfas = tn;
    rxSlot = 5'(rc / 8); rxBit = 3'(7 - rc % 8); rxNfas = rn;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txLinkData = lfsr[0]; txDataIn = lfsr[5]; rxDataIn = lfsr[9];
    if (txSlot == 0 && txBit == 7 && tn) tMask = dlMask;
    if (rxSlot == 0 && rxBit == 7 && rn) rMask = dlMask;
    txSa = (txSlot == 0) && tn && (txBit < 5);
    rxSa = (rxSlot == 0) && rn && (rxBit < 5);
    eTxS = txSa && tMask[txBit];
    eTxD = eTxS ? txLinkData : (txSa ? txDefaultSa[txBit] : txDataIn);
    eRxS = rxSa && rMask[rxBit];
    eRxD = rxDataIn;
    tag = eTxS ? "R1/R3" : (txSa ? "R4" : "R2/R5");
    @(posedge clk);
    @(negedge clk);
    chk(txStrobe == eTxS, eTxS ? "R1 tx strobe" : "R2 tx strobe", int'(txStrobe), int'(eTxS));
    chk(txDataOut == eTxD, tag, int'(txDataOut), int'(eTxD));
    chk(rxStrobe == eRxS, "R9 rx strobe", int'(rxStrobe), int'(eRxS));
    chk(rxDataOut == eRxD, "R6 rx data", int'(rxDataOut), int'(eRxD));
    txPulses += int'(txStrobe);
    rxPulses += int'(rxStrobe);
  endtask

  // One transmit frame; rx runs rxShift cells ahead, flipping its frame flag past the wrap.
  task automatic runFrame(input bit nfas, input int rxShift, input int chgCell, input logic [4:0] newMask);
    for (int c = 0; c < 256; c++) begin
      int r = c + rxShift;
      if (c == chgCell) dlMask = newMask;
      stepCell(c, nfas, r % 256, (r >= 256) ? !nfas : nfas);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!txStrobe && !rxStrobe, "R10 strobes in reset", int'(txStrobe | rxStrobe), 0);
    chk(!txDataOut && !rxDataOut, "R10 data in reset", int'(txDataOut | rxDataOut), 0);
    tMask = '0; rMask = '0;
    rstN = 1'b1;
  endtask

  task automatic testMaskPatterns();
    logic [4:0] pats [4] = '{5'b10000, 5'b00001, 5'b10101, 5'b11111};
    txDefaultSa = 5'b01010;
    foreach (pats[i]) begin
      dlMask = pats[i];
      txPulses = 0;
      runFrame(1'b1, 0, -1, '0);
      chk(txPulses == $countones(pats[i]), "R1 pulses per frame", txPulses, $countones(pats[i]));
      txPulses = 0;
      runFrame(1'b0, 0, -1, '0);
      chk(txPulses == 0, "R2 no pulses in alignment frame", txPulses, 0);
    end
  endtask

  task automatic testDefaults();
    txDefaultSa = 5'b10110;
    dlMask = 5'b01001;
    runFrame(1'b1, 0, -1, '0);
    txDefaultSa = 5'b01001;
    runFrame(1'b1, 0, -1, '0);
  endtask

  task automatic testMidFrameMask();
    dlMask = 5'b00011;
    runFrame(1'b1, 0, -1, '0);
    runFrame(1'b0, 0, -1, '0);
    txPulses = 0;
    runFrame(1'b1, 0, 1, 5'b11100);
    chk(txPulses == 2, "R7 change after load ignored", txPulses, 2);
    txPulses = 0;
    runFrame(1'b1, 0, -1, '0);
    chk(txPulses == 3, "R7 change used at next start", txPulses, 3);
  endtask

  task automatic testZeroMask();
    dlMask = 5'b00000;
    txPulses = 0; rxPulses = 0;
    runFrame(1'b1, 0, -1, '0);
    runFrame(1'b0, 0, -1, '0);
    runFrame(1'b1, 0, -1, '0);
    chk(txPulses == 0 && rxPulses == 0, "R8 zero mask silent", txPulses + rxPulses, 0);
  endtask

  task automatic testRxSlip();
    dlMask = 5'b10110;
    runFrame(1'b1, 0, -1, '0);
    runFrame(1'b0, 0, -1, '0);
    rxPulses = 0;
    runFrame(1'b1, 37, -1, '0);
    runFrame(1'b0, 37, -1, '0);
    runFrame(1'b1, 37, -1, '0);
    runFrame(1'b0, 37, -1, '0);
    chk(rxPulses == 6, "R9 rx pulses after slip", rxPulses, 6);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testMaskPatterns();
    testDefaults();
    testMidFrameMask();
    testZeroMask();
    testRxSlip();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule